// File: doc/BRIEF.md
# ATA sector transfer sequencer

This block is the command-phase controller that sits between an ATA task-file register bank and the media side of a solid-state disk. When the host writes a command code, the block loads the requested sector count and starting logical block address, then moves through the PIO handshake. It raises BSY while the media works, DRQ while the host moves data through the data port, and a one-cycle interrupt pulse at each point where the host must act. Transfers run one sector at a time or in blocks whose size the host chose earlier with a Set Multiple command. When the count is not a whole number of blocks, the final block is shorter.

The media side reports each buffer event with a ready pulse and an optional error flag. For reads the event means data has been loaded, for writes that a block has been committed, and for verify that one sector has been checked. An error flag can be marked correctable. The host side reports each sector it has moved through the data port. At the end of a command the count and address outputs hold either the finished position or the residual count and failing address.

Top module: `ata_xfer_seq`

## Requirements
- R1: A loaded sector count of 0 requests 256 sectors, and a command that completes without error leaves `sec_cnt_out` at 0.
- R2: A write command (code 30h/31h, or C5h in block mode) raises BSY for one cycle, then raises DRQ with BSY low and gives no interrupt before the first block.
- R3: After the last sector of a write block, BSY is high and DRQ low until the media commit pulse. A commit of a non-final block raises DRQ with an interrupt. The final commit drops BSY and raises an interrupt.
- R4: For a read (code 20h/21h), each media ready pulse raises DRQ, drops BSY and pulses the interrupt. After the last sector of the command, DRQ drops with no further interrupt.
- R5: Block-mode read (C4h) and write (C5h) qualify DRQ and interrupt once per block of the configured size. The last block carries the remainder of the count.
- R6: A block-mode read or write issued while block mode is disabled sets ERR and ABRT, pulses the interrupt and never raises BSY or DRQ.
- R7: Set Multiple (C6h) takes the count value as the block size when it is a power of two no larger than MAX_MULT. A value of 0 disables block mode without error. Any other value disables block mode and sets ERR and ABRT. Block mode is disabled after reset, and `mult_size` shows the size (0 = disabled).
- R8: A write commit with the error flag set ends the command with ERR and an interrupt. The address then holds the first sector of the failing block, and the count holds the sectors still outstanding including that block.
- R9: In a read, an uncorrectable error sets ERR, the failing block is still transferred, and the command then stops with address and count at that block's first sector. A correctable error sets CORR and the transfer continues.
- R10: Read Verify (40h/41h) never raises DRQ. It takes one media pulse per sector and pulses the interrupt once, at completion or at the first uncorrectable sector, which is left in the address and count outputs.
- R11: The address advances by one per transferred sector except after the last one, so on success it holds the last sector of the request.
- R12: Any other command code sets ERR and ABRT with an interrupt.
- R13: A command written while BSY or DRQ is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command code |
| sec_cnt_in | input | CNT_W | Sector count register value at command time |
| lba_in | input | LBA_W | Starting logical block address |
| host_sec_done | input | 1 | Host finished moving one sector through the data port |
| media_rdy | input | 1 | Media buffer event (read loaded, write committed, verify checked) |
| media_err | input | 1 | Error flag qualifying media_rdy |
| media_corr | input | 1 | Marks media_err as correctable |
| bsy | output | 1 | Busy status |
| drq | output | 1 | Data request status |
| err | output | 1 | Error status |
| abrt | output | 1 | Command aborted |
| corr | output | 1 | Correctable error seen |
| irq | output | 1 | One-cycle interrupt pulse |
| sec_cnt_out | output | CNT_W | Current sector count |
| lba_out | output | LBA_W | Current sector address |
| mult_size | output | CNT_W | Configured block size, 0 when disabled |

## Verification
The hardest case to reach from the ports is a media error landing on a block in the middle of a block-mode transfer, with a count that leaves a short last block. Reaching it takes a prior Set Multiple, a count that is not a multiple of the size, and an error pulse timed to one specific commit or load among several. The stimulus plays both host and media roles in one loop that answers DRQ and BSY as they appear and numbers the media events, so it can aim the error flag at any chosen block. Random counts, block sizes and failure points are mixed with directed cases for a 256-sector request, rejected sizes and a command issued during DRQ.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_XFER, ST_MEDIA} seq_st_t;
   typedef enum logic [1:0] {MD_RD, MD_WR, MD_VFY} seq_mode_t;

   localparam logic [6:0] OPH_READ   = 7'h10; // 20h/21h
   localparam logic [6:0] OPH_WRITE  = 7'h18; // 30h/31h
   localparam logic [6:0] OPH_VERIFY = 7'h20; // 40h/41h
   localparam logic [7:0] OP_READ_BLK  = 8'hC4;
   localparam logic [7:0] OP_WRITE_BLK = 8'hC5;
   localparam logic [7:0] OP_SET_BLK   = 8'hC6;
endpackage

// File: rtl/ata_mult_cfg.sv
module ata_mult_cfg #(
   parameter int CNT_W    = 8,
   parameter int MAX_MULT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [CNT_W-1:0] set_val,
   output logic [CNT_W-1:0] mult,
   output logic             set_bad
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_MULT);

   logic pow2, ok;
   assign pow2    = ((set_val & (set_val - ONE)) == '0);
   assign ok      = (set_val != '0) && pow2 && (set_val <= MAXV);
   assign set_bad = (set_val != '0) && !ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mult <= '0;
      else if (set_en) mult <= ok ? set_val : '0;
   end
endmodule

// File: rtl/ata_blk_size.sv
module ata_blk_size #(
   parameter int SCW = 9
) (
   input  logic [SCW-1:0] blk,
   input  logic [SCW-1:0] rem,
   output logic [SCW-1:0] n
);
   assign n = (blk < rem) ? blk : rem;
endmodule

// File: rtl/ata_addr_track.sv
module ata_addr_track #(
   parameter int CNT_W = 8,
   parameter int LBA_W = 28,
   localparam int SCW  = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [LBA_W-1:0] load_lba,
   input  logic             adv,
   input  logic [SCW-1:0]   adv_n,
   output logic [SCW-1:0]   rem,
   output logic [LBA_W-1:0] lba
);
   localparam logic [SCW-1:0] ONE  = SCW'(1);
   localparam logic [SCW-1:0] FULL = ONE << CNT_W;

   logic [SCW-1:0] step;
   assign step = (rem == adv_n) ? (adv_n - ONE) : adv_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0;
         lba <= '0;
      end else if (load) begin
         rem <= (load_cnt == '0) ? FULL : SCW'(load_cnt);
         lba <= load_lba;
      end else if (adv) begin
         rem <= rem - adv_n;
         lba <= lba + LBA_W'(step);
      end
   end
endmodule

// File: rtl/ata_xfer_seq.sv
module ata_xfer_seq
   import ata_seq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int LBA_W    = 28,
   parameter int MAX_MULT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [7:0]       cmd_code,
   input  logic [CNT_W-1:0] sec_cnt_in,
   input  logic [LBA_W-1:0] lba_in,
   input  logic             host_sec_done,
   input  logic             media_rdy,
   input  logic             media_err,
   input  logic             media_corr,
   output logic             bsy,
   output logic             drq,
   output logic             err,
   output logic             abrt,
   output logic             corr,
   output logic             irq,
   output logic [CNT_W-1:0] sec_cnt_out,
   output logic [LBA_W-1:0] lba_out,
   output logic [CNT_W-1:0] mult_size
);
   localparam int SCW = CNT_W + 1;
   localparam logic [SCW-1:0] ONE_S = SCW'(1);

   generate
      if (MAX_MULT < 1 || MAX_MULT > (1 << (CNT_W - 1)) || (MAX_MULT & (MAX_MULT - 1)) != 0) begin : g_bad_max
         $error("MAX_MULT must be a power of two within the count range");
      end
      if (LBA_W < CNT_W) begin : g_bad_lba
         $error("LBA_W must not be narrower than CNT_W");
      end
   endgenerate

   seq_st_t   st;
   seq_mode_t mode;
   logic [SCW-1:0] blk, blk_left, rem, n_now, n_next, rem_after;
   logic stop_q;

   logic is_rd, is_wr, is_vfy, is_rdb, is_wrb, is_set, accept, blk_on, ld;
   logic set_bad, adv, hard_err;
   logic [SCW-1:0] adv_n;

   assign is_rd  = (cmd_code[7:1] == OPH_READ);
   assign is_wr  = (cmd_code[7:1] == OPH_WRITE);
   assign is_vfy = (cmd_code[7:1] == OPH_VERIFY);
   assign is_rdb = (cmd_code == OP_READ_BLK);
   assign is_wrb = (cmd_code == OP_WRITE_BLK);
   assign is_set = (cmd_code == OP_SET_BLK);
   assign blk_on = (mult_size != '0);
   assign accept = cmd_we && (st == ST_IDLE);
   assign ld     = accept && (is_rd || is_wr || is_vfy || ((is_rdb || is_wrb) && blk_on));
   assign hard_err = media_err && !media_corr;

   ata_mult_cfg #(.CNT_W(CNT_W), .MAX_MULT(MAX_MULT)) u_cfg (
      .clk(clk), .rst_n(rst_n), .set_en(accept && is_set), .set_val(sec_cnt_in),
      .mult(mult_size), .set_bad(set_bad));

   ata_blk_size #(.SCW(SCW)) u_sz_now  (.blk(blk), .rem(rem),       .n(n_now));
   assign rem_after = rem - n_now;
   ata_blk_size #(.SCW(SCW)) u_sz_next (.blk(blk), .rem(rem_after), .n(n_next));

   always_comb begin
      adv   = 1'b0;
      adv_n = ONE_S;
      if (st == ST_MEDIA && media_rdy && mode == MD_VFY && !hard_err) adv = 1'b1;
      if (st == ST_MEDIA && media_rdy && mode == MD_WR && !media_err) begin
         adv   = 1'b1;
         adv_n = n_now;
      end
      if (st == ST_XFER && host_sec_done && mode == MD_RD && !stop_q) adv = 1'b1;
   end

   ata_addr_track #(.CNT_W(CNT_W), .LBA_W(LBA_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_cnt(sec_cnt_in), .load_lba(lba_in),
      .adv(adv), .adv_n(adv_n), .rem(rem), .lba(lba_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         mode     <= MD_RD;
         blk      <= ONE_S;
         blk_left <= '0;
         stop_q   <= 1'b0;
         err      <= 1'b0;
         abrt     <= 1'b0;
         corr     <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         unique case (st)
            ST_IDLE: if (cmd_we) begin
               err  <= 1'b0;
               abrt <= 1'b0;
               corr <= 1'b0;
               if (is_set) begin
                  irq <= 1'b1;
                  if (set_bad) begin
                     err  <= 1'b1;
                     abrt <= 1'b1;
                  end
               end else if (ld) begin
                  stop_q <= 1'b0;
                  blk    <= (is_rdb || is_wrb) ? SCW'(mult_size) : ONE_S;
                  mode   <= (is_wr || is_wrb) ? MD_WR : (is_vfy ? MD_VFY : MD_RD);
                  st     <= (is_wr || is_wrb) ? ST_PREP : ST_MEDIA;
               end else begin
                  err  <= 1'b1;
                  abrt <= 1'b1;
                  irq  <= 1'b1;
               end
            end
            ST_PREP: begin
               st       <= ST_XFER;
               blk_left <= n_now;
            end
            ST_MEDIA: if (media_rdy) begin
               unique case (mode)
                  MD_RD: begin
                     st       <= ST_XFER;
                     irq      <= 1'b1;
                     blk_left <= n_now;
                     if (hard_err) begin
                        err    <= 1'b1;
                        stop_q <= 1'b1;
                     end
                     if (media_err && media_corr) corr <= 1'b1;
                  end
                  MD_VFY: begin
                     if (media_err && media_corr) corr <= 1'b1;
                     if (hard_err) begin
                        err <= 1'b1;
                        irq <= 1'b1;
                        st  <= ST_IDLE;
                     end else if (rem == ONE_S) begin
                        irq <= 1'b1;
                        st  <= ST_IDLE;
                     end
                  end
                  default: begin
                     irq <= 1'b1;
                     if (media_err) begin
                        err <= 1'b1;
                        st  <= ST_IDLE;
                     end else if (rem == n_now) begin
                        st <= ST_IDLE;
                     end else begin
                        st       <= ST_XFER;
                        blk_left <= n_next;
                     end
                  end
               endcase
            end
            ST_XFER: if (host_sec_done) begin
               blk_left <= blk_left - ONE_S;
               if (blk_left == ONE_S) begin
                  if (mode == MD_WR)                    st <= ST_MEDIA;
                  else if (stop_q || rem == ONE_S)      st <= ST_IDLE;
                  else                                  st <= ST_MEDIA;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign bsy         = (st == ST_PREP) || (st == ST_MEDIA);
   assign drq         = (st == ST_XFER);
   assign sec_cnt_out = rem[CNT_W-1:0];
endmodule

// File: rtl/ata_xfer_seq_chk.sv
module ata_xfer_seq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_we,
   input logic [7:0]       cmd_code,
   input logic             bsy,
   input logic             drq,
   input logic             err,
   input logic             abrt,
   input logic             irq,
   input logic [CNT_W-1:0] sec_cnt_out,
   input logic [CNT_W-1:0] mult_size
);
   logic idle_w;
   assign idle_w = !bsy && !drq;

   // R3: the device never asserts both handshake flags at once
   p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(bsy && drq));

   // R6: abort reported only together with the error flag
   p_abrt_has_err_r6: assert property (@(posedge clk) disable iff (!rst_n) abrt |-> err);

   // R6: block-mode command with block mode disabled is rejected
   p_blk_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && idle_w && (cmd_code == 8'hC4 || cmd_code == 8'hC5) && mult_size == '0)
      |=> (abrt && err && irq && !bsy && !drq));

   // R2: write raises BSY, then DRQ without an interrupt
   p_write_first_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && idle_w && cmd_code == 8'h30) |=> bsy ##1 (drq && !irq));

   // R10: a drop of BSY straight to idle is always signalled
   p_bsy_end_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bsy) && !drq) |-> irq);

   // R1: error-free completion leaves a zero count
   p_done_cnt_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((($fell(bsy) && !drq) || ($fell(drq) && !bsy)) && !err) |-> (sec_cnt_out == '0));
endmodule

bind ata_xfer_seq ata_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
   .bsy(bsy), .drq(drq), .err(err), .abrt(abrt), .irq(irq),
   .sec_cnt_out(sec_cnt_out), .mult_size(mult_size));

// File: tb/ata_xfer_seq_test.sv
module ata_xfer_seq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_we = 1'b0;
   logic [7:0] cmd_code = '0;
   logic [7:0] sec_cnt_in = '0;
   logic [27:0] lba_in = '0;
   logic host_sec_done = 1'b0, media_rdy = 1'b0, media_err = 1'b0, media_corr = 1'b0;
   logic bsy, drq, err, abrt, corr, irq;
   logic [7:0] sec_cnt_out, mult_size;
   logic [27:0] lba_out;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int cur_mult = 0;

   always #4 clk = ~clk;

   ata_xfer_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
      .sec_cnt_in(sec_cnt_in), .lba_in(lba_in), .host_sec_done(host_sec_done),
      .media_rdy(media_rdy), .media_err(media_err), .media_corr(media_corr),
      .bsy(bsy), .drq(drq), .err(err), .abrt(abrt), .corr(corr), .irq(irq),
      .sec_cnt_out(sec_cnt_out), .lba_out(lba_out), .mult_size(mult_size));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit mult_valid(input int v);
      return v != 0 && (v & (v - 1)) == 0 && v <= 16;
   endfunction

   // Set Multiple: R7
   task automatic do_set(input int v);
      int irqs = 0;
      cmd_code = 8'hC6; sec_cnt_in = 8'(v); cmd_we = 1'b1;
      @(negedge clk); cmd_we = 1'b0;
      if (irq) irqs++;
      @(negedge clk);
      cur_mult = mult_valid(v) ? v : 0;
      chk(mult_size == 8'(cur_mult), "R7", "block size", mult_size, cur_mult);
      chk(abrt == (v != 0 && !mult_valid(v)), "R7", "abort flag", abrt, (v != 0 && !mult_valid(v)));
      chk(irqs == 1 && !bsy && !drq, "R7", "irq count", irqs, 1);
   endtask

   // Runs a transfer command playing host and media. fail_at: block index
   // (read/write) or sector index (verify) that reports an error.
   task automatic run(input logic [7:0] code, input int cnt, input logic [27:0] lba0,
                      input int fail_at, input bit corr_in, input bit poke);
      int N, b, nblk, k, S, irqs, ndrq, mev, g;
      bit prev_drq, wr, rd, vf, blkm, rej, failing;
      int e_irq, e_drq, e_cnt; logic [27:0] e_lba; bit e_err, e_corr;
      string rq;
      N = (cnt == 0) ? 256 : cnt;
      wr = (code[7:1] == 7'h18) || code == 8'hC5;
      rd = (code[7:1] == 7'h10) || code == 8'hC4;
      vf = (code[7:1] == 7'h20);
      blkm = (code == 8'hC4 || code == 8'hC5);
      rej = !(wr || rd || vf) || (blkm && cur_mult == 0);
      b = blkm ? cur_mult : 1;
      if (b == 0) b = 1;
      nblk = (N + b - 1) / b;
      e_corr = 0; e_err = 0; e_cnt = 0; e_lba = lba0 + 28'(N - 1);
      if (rej) begin
         e_irq = 1; e_drq = 0; e_err = 1;
         rq = blkm ? "R6" : "R12";
      end else if (vf) begin
         e_drq = 0; e_irq = 1; rq = "R10";
         if (fail_at < N) begin e_err = 1; e_cnt = N - fail_at; e_lba = lba0 + 28'(fail_at); end
      end else begin
         rq = blkm ? "R5" : (wr ? "R3" : "R4");
         failing = (fail_at < nblk) && !(rd && corr_in);
         if (failing) begin
            k = fail_at; S = k * b;
            e_drq = k + 1; e_irq = k + 1; e_err = 1;
            e_cnt = N - S; e_lba = lba0 + 28'(S);
         end else begin
            e_drq = nblk; e_irq = nblk;
            e_corr = rd && corr_in && (fail_at < nblk);
         end
      end

      cmd_code = code; sec_cnt_in = 8'(cnt); lba_in = lba0; cmd_we = 1'b1;
      @(negedge clk); cmd_we = 1'b0;
      irqs = 0; ndrq = 0; mev = 0; prev_drq = 0; g = 0;
      forever begin
         if (irq) irqs++;
         host_sec_done = 0; media_rdy = 0; media_err = 0; media_corr = 0; cmd_we = 0;
         if (!bsy && !drq) break;
         if (drq) begin
            if (!prev_drq) begin
               ndrq++;
               if (poke && ndrq == 1) begin // R13: command during DRQ
                  cmd_code = 8'hC6; sec_cnt_in = 8'd2; cmd_we = 1'b1;
               end
            end
            host_sec_done = 1;
         end else if (!wr || prev_drq) begin
            media_rdy = 1;
            media_err = (mev == fail_at);
            media_corr = corr_in;
            mev++;
         end
         prev_drq = drq;
         g++;
         if (g > 20000) break;
         @(negedge clk);
      end
      chk(irqs == e_irq, rq, "interrupt count", irqs, e_irq);
      chk(ndrq == e_drq, rq, "DRQ phases", ndrq, e_drq);
      chk(err == e_err, e_err && !rej ? (wr ? "R8" : (vf ? "R10" : "R9")) : rq, "err flag", err, e_err);
      chk(abrt == rej, rq, "abort flag", abrt, rej);
      if (!rej) begin
         chk(sec_cnt_out == 8'(e_cnt), e_err ? (wr ? "R8" : "R9") : "R1", "count", sec_cnt_out, 8'(e_cnt));
         chk(lba_out == e_lba, e_err ? (wr ? "R8" : "R9") : "R11", "address", lba_out, e_lba);
         chk(corr == e_corr, "R9", "corr flag", corr, e_corr);
      end
      if (poke) chk(mult_size == 8'(cur_mult), "R13", "block size after ignored command", mult_size, cur_mult);
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bsy && !drq && !irq && !err, "R7", "reset flags", {bsy, drq, irq, err}, 0);
      chk(mult_size == 0, "R7", "reset block size", mult_size, 0);

      run(8'h30, 8, 28'h100, 2, 0, 0);       // R8: 8 sectors, 3rd fails -> count 6
      run(8'hC4, 5, 28'h10, 99, 0, 0);       // R6: block mode disabled
      run(8'hEC, 1, 28'h0, 99, 0, 0);        // R12: unsupported code
      do_set(3);                             // R7: rejected size
      do_set(0);                             // R7: disable without error
      do_set(4);
      run(8'hC4, 10, 28'h200, 99, 0, 0);     // R5: 4+4+2
      run(8'hC5, 10, 28'h300, 99, 0, 1);     // R5, R13
      run(8'hC5, 0, 28'h400, 99, 0, 0);      // R1: 256 sectors in blocks
      run(8'h30, 0, 28'h800, 99, 0, 0);      // R1, R2: 256 single sectors
      run(8'h40, 5, 28'h20, 99, 0, 0);       // R10
      run(8'h40, 6, 28'h40, 3, 0, 0);        // R10 failing sector
      run(8'hC4, 11, 28'h60, 1, 0, 0);       // R9 uncorrectable mid block
      run(8'hC4, 11, 28'h80, 1, 1, 0);       // R9 correctable
      run(8'h20, 7, 28'h90, 99, 0, 1);       // R4, R13

      for (int i = 0; i < 60; i++) begin
         int op, cnt, fl;
         logic [7:0] code;
         op = $urandom % 7;
         cnt = $urandom % 24;
         fl = (($urandom % 3) == 0) ? 999 : $urandom % 12;
         case (op)
            0: code = 8'h20; 1: code = 8'h31; 2: code = 8'h41;
            3: code = 8'hC4; 4: code = 8'hC5; default: code = 8'hC6;
         endcase
         if (code == 8'hC6) begin
            int vals[7] = '{0, 1, 2, 4, 8, 16, 6};
            do_set(vals[$urandom % 7]);
         end else begin
            run(code, cnt, 28'($urandom % 32'h0400_0000), fl,
                (code != 8'h41) && (($urandom % 2) == 1), 0);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule